// File: doc/BRIEF.md
# Multiplexed LED Matrix Scan Controller

This block scans a chain of LED matrix panels built from serial shift registers. A frame is a fixed run of slots. Each row of the panel gets one slot, and one empty pad slot follows so that the last row stays lit as long as the others. In a row slot the controller reads that row's bitmap from a frame buffer. It then shifts the bitmap out two pixels per clock on two data lanes. Alongside, a third lane carries a periodic row-enable pattern that selects the row being shown. When the shift is complete, the controller parks the shift clock low and pulses an active-low latch, which moves the shifted data onto the panel outputs.

A frame starts on a frame-rate tick. A tick that arrives while a frame is still being scanned is held. The next frame then begins immediately after the pad slot of the current one, so slot spacing stays constant across the frame boundary.

The frame buffer port has a fixed read latency of one clock and no back-pressure. A read request is a single-cycle `fb_rd_en` with an address. The memory must present the row word on `fb_rdata` in the following cycle, and the controller never stalls waiting for it. All other pins are plain control and status signals with no handshake.

Top module: `lmx_scan_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, `sclk`, `lane_a`, `lane_b`, `lane_row`, `busy` and `fb_rd_en` are 0, `latch_n` is 1 and `row_idx` is 0.
- R2: `frame_tick` is registered. When idle, `busy` is still 0 after the clock edge that samples the tick high and is 1 after the next edge.
- R3: A frame has ROWS+1 slots. `row_idx` shows 0 to ROWS-1 for the row slots and ROWS for the pad slot. `busy` falls after the pad slot's latch pulse when no tick is held, so one frame gives exactly ROWS+1 latch pulses.
- R4: Each row slot issues exactly one single-cycle `fb_rd_en`, with `fb_addr` equal to the row index. The pad slot issues none. Data is taken from `fb_rdata` one clock after the request.
- R5: For shift bit k, where k=0 is shifted first and there are ROW_PIXELS/2 bits, `lane_a` carries pixel 2k and `lane_b` carries pixel 2k+1. Pixel j is bit j of the row word.
- R6: In row slot r, `lane_row` is 1 at shift bits k where k mod ROWS equals r, and 0 at all other bits.
- R7: In the pad slot, `lane_a`, `lane_b` and `lane_row` are 0 at every shift bit.
- R8: Each shift bit holds `sclk` low for HALF_DIV clocks and then high for HALF_DIV clocks. The lanes change only while `sclk` is low. A slot has exactly ROW_PIXELS/2 rising edges of `sclk`.
- R9: `latch_n` goes low for exactly LATCH_CLKS clocks. `sclk` is low throughout the pulse, in the cycle before it falls and in the cycle after it rises.
- R10: The interval from one latch falling edge to the next within a run of slots is exactly 2 + 2·HALF_DIV·(ROW_PIXELS/2) + 2·GAP_CLKS + LATCH_CLKS clocks. This also holds across back-to-back frames.
- R11: A tick that arrives while `busy` is 1 is held. The next frame starts right after the pad slot with `busy` staying 1. Any number of ticks within one frame merge into a single further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | Frame-rate pulse that requests a frame |
| fb_rd_en | output | 1 | Frame buffer read request, one cycle |
| fb_addr | output | $clog2(ROWS) | Row address for the read |
| fb_rdata | input | ROW_PIXELS | Row word, valid one clock after the request |
| sclk | output | 1 | Panel shift clock, idle low |
| lane_a | output | 1 | Even-pixel data lane |
| lane_b | output | 1 | Odd-pixel data lane |
| lane_row | output | 1 | Row-enable pattern lane |
| latch_n | output | 1 | Active-low panel latch |
| busy | output | 1 | A frame is being scanned |
| row_idx | output | $clog2(ROWS+1) | Current slot, ROWS for the pad slot |

## Verification
A sequencer slot index that goes wrong appears within one row slot. Either the pixel lanes carry another row's word or the row-enable pulse sits at the wrong bit offset. A miscounted pad slot shows up as the wrong number of latch pulses per frame, or as a lit row when all lanes should be dark. Divider or timer errors change the spacing between latch pulses by a fixed number of clocks in every slot. They can also let a shift clock edge fall inside or right beside the latch pulse, which is visible within a few clocks of the first latch.

// File: rtl/lmx_pkg.sv
package lmx_pkg;
  typedef enum logic [1:0] {
    SER_IDLE,
    SER_LOAD,
    SER_LOW,
    SER_HIGH
  } ser_state_t;

  typedef enum logic [1:0] {
    LT_IDLE,
    LT_PRE,
    LT_PULSE,
    LT_POST
  } lat_state_t;
endpackage

// File: rtl/lmx_frame_seq.sv
module lmx_frame_seq #(
  parameter int ROWS   = 16,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              slot_done,
  output logic              busy,
  output logic              slot_start,
  output logic [SLOT_W-1:0] slot_idx
);
  logic tick_q;
  logic pending;
  logic req;
  logic last_slot;
  logic launch_idle;
  logic launch_chain;

  assign req          = pending | tick_q;
  assign last_slot    = (slot_idx == SLOT_W'(ROWS));
  assign launch_idle  = !busy && req;
  assign launch_chain = busy && slot_done && last_slot && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q     <= 1'b0;
      pending    <= 1'b0;
      busy       <= 1'b0;
      slot_start <= 1'b0;
      slot_idx   <= '0;
    end else begin
      tick_q     <= frame_tick;
      pending    <= req && !(launch_idle || launch_chain);
      slot_start <= 1'b0;
      if (launch_idle || launch_chain) begin
        busy       <= 1'b1;
        slot_idx   <= '0;
        slot_start <= 1'b1;
      end else if (busy && slot_done) begin
        if (last_slot) begin
          busy     <= 1'b0;
          slot_idx <= '0;
        end else begin
          slot_idx   <= slot_idx + 1'b1;
          slot_start <= 1'b1;
        end
      end
    end
  end

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= SLOT_W'(ROWS));

  // R3
  busy_end_after_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(slot_idx) == SLOT_W'(ROWS));

  // R11
  start_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> busy);
endmodule

// File: rtl/lmx_row_serializer.sv
module lmx_row_serializer
  import lmx_pkg::*;
#(
  parameter int ROWS       = 16,
  parameter int ROW_PIXELS = 32,
  parameter int HALF_DIV   = 2,
  parameter int SLOT_W     = 5,
  parameter int ROW_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_start,
  input  logic [SLOT_W-1:0]     slot_idx,
  input  logic [ROW_PIXELS-1:0] fb_rdata,
  output logic                  fb_rd_en,
  output logic [ROW_W-1:0]      fb_addr,
  output logic                  sclk,
  output logic                  lane_a,
  output logic                  lane_b,
  output logic                  lane_row,
  output logic                  shift_done
);
  localparam int SHIFT_BITS = ROW_PIXELS / 2;
  localparam int BIT_W      = (SHIFT_BITS > 1) ? $clog2(SHIFT_BITS) : 1;
  localparam int DIV_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  ser_state_t            state;
  logic [ROW_PIXELS-1:0] pix;
  logic [BIT_W-1:0]      bit_cnt;
  logic [DIV_W-1:0]      div_cnt;
  logic [ROW_W-1:0]      pos;
  logic [ROW_W-1:0]      row_sel;
  logic                  pad;
  logic                  shifting;
  logic                  div_end;
  logic                  last_bit;

  assign fb_rd_en = slot_start && (slot_idx < SLOT_W'(ROWS));
  assign fb_addr  = slot_idx[ROW_W-1:0];

  assign shifting = (state == SER_LOW) || (state == SER_HIGH);
  assign div_end  = (div_cnt == DIV_W'(HALF_DIV - 1));
  assign last_bit = (bit_cnt == BIT_W'(SHIFT_BITS - 1));

  assign sclk       = (state == SER_HIGH);
  assign lane_a     = shifting && pix[0];
  assign lane_b     = shifting && pix[1];
  assign lane_row   = shifting && !pad && (pos == row_sel);
  assign shift_done = (state == SER_HIGH) && div_end && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SER_IDLE;
      pix     <= '0;
      bit_cnt <= '0;
      div_cnt <= '0;
      pos     <= '0;
      row_sel <= '0;
      pad     <= 1'b0;
    end else begin
      unique case (state)
        SER_IDLE: begin
          if (slot_start) begin
            row_sel <= slot_idx[ROW_W-1:0];
            pad     <= (slot_idx == SLOT_W'(ROWS));
            state   <= SER_LOAD;
          end
        end
        SER_LOAD: begin
          pix     <= pad ? '0 : fb_rdata;
          bit_cnt <= '0;
          div_cnt <= '0;
          pos     <= '0;
          state   <= SER_LOW;
        end
        SER_LOW: begin
          if (div_end) begin
            div_cnt <= '0;
            state   <= SER_HIGH;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        SER_HIGH: begin
          if (div_end) begin
            div_cnt <= '0;
            if (last_bit) begin
              state <= SER_IDLE;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              pix     <= pix >> 2;
              pos     <= (pos == ROW_W'(ROWS - 1)) ? '0 : pos + 1'b1;
              state   <= SER_LOW;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: state <= SER_IDLE;
      endcase
    end
  end

  // R8
  lanes_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable({lane_a, lane_b, lane_row}));

  // R8
  clk_parks_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_done |=> !sclk);

  // R7
  pad_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shifting && pad) |-> !(lane_a || lane_b || lane_row));
endmodule

// File: rtl/lmx_latch_timer.sv
module lmx_latch_timer
  import lmx_pkg::*;
#(
  parameter int LATCH_CLKS = 3,
  parameter int GAP_CLKS   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_done,
  output logic latch_n,
  output logic slot_done
);
  localparam int MAX_CNT = (LATCH_CLKS > GAP_CLKS) ? LATCH_CLKS : GAP_CLKS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  lat_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             gap_end;
  logic             pulse_end;

  assign gap_end   = (cnt == CNT_W'(GAP_CLKS - 1));
  assign pulse_end = (cnt == CNT_W'(LATCH_CLKS - 1));
  assign latch_n   = (state != LT_PULSE);
  assign slot_done = (state == LT_POST) && gap_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LT_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        LT_IDLE: begin
          cnt <= '0;
          if (shift_done) state <= LT_PRE;
        end
        LT_PRE: begin
          if (gap_end) begin
            cnt   <= '0;
            state <= LT_PULSE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        LT_PULSE: begin
          if (pulse_end) begin
            cnt   <= '0;
            state <= LT_POST;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        LT_POST: begin
          if (gap_end) begin
            cnt   <= '0;
            state <= LT_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= LT_IDLE;
      endcase
    end
  end

  // R9
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done) |-> (state == LT_IDLE));
endmodule

// File: rtl/lmx_scan_ctrl.sv
module lmx_scan_ctrl #(
  parameter int ROWS       = 16,
  parameter int ROW_PIXELS = 32,
  parameter int HALF_DIV   = 2,
  parameter int LATCH_CLKS = 3,
  parameter int GAP_CLKS   = 1,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SLOT_W = $clog2(ROWS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_tick,
  output logic                  fb_rd_en,
  output logic [ROW_W-1:0]      fb_addr,
  input  logic [ROW_PIXELS-1:0] fb_rdata,
  output logic                  sclk,
  output logic                  lane_a,
  output logic                  lane_b,
  output logic                  lane_row,
  output logic                  latch_n,
  output logic                  busy,
  output logic [SLOT_W-1:0]     row_idx
);
  localparam int LRUN_W = $clog2(LATCH_CLKS + 2);

  logic slot_start;
  logic slot_done;
  logic shift_done;

  lmx_frame_seq #(
    .ROWS   (ROWS),
    .SLOT_W (SLOT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .slot_done  (slot_done),
    .busy       (busy),
    .slot_start (slot_start),
    .slot_idx   (row_idx)
  );

  lmx_row_serializer #(
    .ROWS       (ROWS),
    .ROW_PIXELS (ROW_PIXELS),
    .HALF_DIV   (HALF_DIV),
    .SLOT_W     (SLOT_W),
    .ROW_W      (ROW_W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .slot_idx   (row_idx),
    .fb_rdata   (fb_rdata),
    .fb_rd_en   (fb_rd_en),
    .fb_addr    (fb_addr),
    .sclk       (sclk),
    .lane_a     (lane_a),
    .lane_b     (lane_b),
    .lane_row   (lane_row),
    .shift_done (shift_done)
  );

  lmx_latch_timer #(
    .LATCH_CLKS (LATCH_CLKS),
    .GAP_CLKS   (GAP_CLKS)
  ) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_done (shift_done),
    .latch_n    (latch_n),
    .slot_done  (slot_done)
  );

  logic [LRUN_W-1:0] lat_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_run <= '0;
    else if (!latch_n) lat_run <= lat_run + 1'b1;
    else               lat_run <= '0;
  end

  // R9
  latch_clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_n |-> !sclk);

  // R9
  latch_guard_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_n) |-> !$past(sclk));

  // R9
  latch_guard_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_n) |-> !sclk);

  // R9
  latch_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_run <= LRUN_W'(LATCH_CLKS));

  // R4
  read_row_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en |-> (row_idx < SLOT_W'(ROWS)) && busy);
endmodule

// File: tb/test_lmx_scan_ctrl.sv
module test_lmx_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 16;
  localparam int ROW_PIXELS = 32;
  localparam int HALF_DIV   = 2;
  localparam int LATCH_CLKS = 3;
  localparam int GAP_CLKS   = 1;
  localparam int BITS       = ROW_PIXELS / 2;
  localparam int PERIOD     = 2 + 2 * HALF_DIV * BITS + 2 * GAP_CLKS + LATCH_CLKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0;
  logic fb_rd_en;
  logic [3:0] fb_addr;
  logic [ROW_PIXELS-1:0] fb_rdata = '0;
  logic sclk, lane_a, lane_b, lane_row, latch_n, busy;
  logic [4:0] row_idx;

  logic [ROW_PIXELS-1:0] mem [ROWS];

  int n_checks = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) if (fb_rd_en) fb_rdata <= mem[fb_addr];

  lmx_scan_ctrl #(
    .ROWS(ROWS), .ROW_PIXELS(ROW_PIXELS), .HALF_DIV(HALF_DIV),
    .LATCH_CLKS(LATCH_CLKS), .GAP_CLKS(GAP_CLKS)
  ) i_lmx_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .fb_rd_en(fb_rd_en), .fb_addr(fb_addr), .fb_rdata(fb_rdata),
    .sclk(sclk), .lane_a(lane_a), .lane_b(lane_b), .lane_row(lane_row),
    .latch_n(latch_n), .busy(busy), .row_idx(row_idx)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_lanes(input int slot, input int k);
    logic [2:0] v;
    if (slot >= ROWS) return 3'b000;
    v[2] = mem[slot][2 * k];
    v[1] = mem[slot][2 * k + 1];
    v[0] = ((k % ROWS) == slot);
    return v;
  endfunction

  // monitor state
  bit   mon_on = 0;
  bit   p_sclk = 0, p_latch = 1, p_busy = 0, fall_valid = 0;
  int   bitk = 0, mon_slot = 0, lat_len = 0, hi_len = 0;
  int   cyc = 0, last_fall = 0;
  int   latches = 0, reads = 0, busy_falls = 0;
  logic [2:0] hi_lanes = '0;

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (fb_rd_en) begin
        check(fb_addr == mon_slot && mon_slot < ROWS, "R4 read address", fb_addr, mon_slot);
        reads++;
      end
      if (sclk && !p_sclk) begin
        check({lane_a, lane_b, lane_row} == exp_lanes(mon_slot, bitk),
              mon_slot == ROWS ? "R7 pad lanes" : "R5/R6 lanes",
              {lane_a, lane_b, lane_row}, exp_lanes(mon_slot, bitk));
        check(row_idx == mon_slot, "R3 row_idx", row_idx, mon_slot);
        hi_lanes = {lane_a, lane_b, lane_row};
        hi_len = 1;
        bitk++;
      end else if (sclk && p_sclk) begin
        check({lane_a, lane_b, lane_row} == hi_lanes, "R8 lanes stable high",
              {lane_a, lane_b, lane_row}, hi_lanes);
        hi_len++;
      end else if (!sclk && p_sclk) begin
        check(hi_len == HALF_DIV, "R8 high width", hi_len, HALF_DIV);
      end
      if (!latch_n) begin
        check(!sclk, "R9 sclk low in latch", sclk, 0);
        lat_len++;
      end
      if (!latch_n && p_latch) begin
        check(!p_sclk, "R9 sclk low before latch", p_sclk, 0);
        check(bitk == BITS, "R8 bits per slot", bitk, BITS);
        if (fall_valid)
          check(cyc - last_fall == PERIOD, "R10 slot period", cyc - last_fall, PERIOD);
        last_fall = cyc;
        fall_valid = 1;
      end
      if (latch_n && !p_latch) begin
        check(lat_len == LATCH_CLKS, "R9 latch width", lat_len, LATCH_CLKS);
        check(!sclk, "R9 sclk low after latch", sclk, 0);
        lat_len = 0;
        bitk = 0;
        latches++;
        mon_slot = (mon_slot == ROWS) ? 0 : mon_slot + 1;
      end
      if (!busy && p_busy) busy_falls++;
      if (!busy) fall_valid = 0;
    end
    p_sclk  = sclk;
    p_latch = latch_n;
    p_busy  = busy;
  end

  task automatic tick_once();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic fill_mem();
    for (int r = 0; r < ROWS; r++) mem[r] = {$urandom, $urandom};
  endtask

  task automatic one_frame(input string tag);
    int l0, r0;
    l0 = latches; r0 = reads;
    tick_once();
    @(negedge clk);
    check(busy, {tag, " R2 busy"}, busy, 1);
    wait_idle();
    check(latches - l0 == ROWS + 1, {tag, " R3 latches per frame"}, latches - l0, ROWS + 1);
    check(reads - r0 == ROWS, {tag, " R4 reads per frame"}, reads - r0, ROWS);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int r = 0; r < ROWS; r++) mem[r] = '0;
    repeat (3) @(negedge clk);
    check({sclk, lane_a, lane_b, lane_row, busy, fb_rd_en} == 6'b0, "R1 reset outputs",
          {sclk, lane_a, lane_b, lane_row, busy, fb_rd_en}, 0);
    check(latch_n == 1'b1, "R1 reset latch", latch_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(latch_n && !busy && row_idx == 0 && !sclk, "R1 after release",
          {latch_n, busy, row_idx, sclk}, 8'h80);
    mon_on = 1;

    // R2 timing, directed, with a ramp pattern
    for (int r = 0; r < ROWS; r++) mem[r] = 32'h0001_0001 << r;
    frame_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_tick = 1'b0;
    check(!busy, "R2 busy one edge after tick", busy, 0);
    @(negedge clk);
    check(busy, "R2 busy two edges after tick", busy, 1);
    wait_idle();
    check(latches == ROWS + 1, "R3 first frame latches", latches, ROWS + 1);

    // all ones and all zeros corner patterns
    for (int r = 0; r < ROWS; r++) mem[r] = '1;
    one_frame("ones");
    for (int r = 0; r < ROWS; r++) mem[r] = '0;
    one_frame("zeros");

    // random frames with random idle gaps
    for (int i = 0; i < 5; i++) begin
      fill_mem();
      repeat ($urandom_range(0, 20)) @(negedge clk);
      one_frame("rand");
    end

    // R11: ticks during a frame are held and merged
    begin
      int l0, f0;
      fill_mem();
      l0 = latches; f0 = busy_falls;
      tick_once();
      repeat (200) @(negedge clk);
      tick_once();
      repeat (300) @(negedge clk);
      tick_once();
      wait_idle();
      check(latches - l0 == 2 * (ROWS + 1), "R11 merged frames", latches - l0, 2 * (ROWS + 1));
      check(busy_falls - f0 == 1, "R11 busy held across chain", busy_falls - f0, 1);
    end

    // a tick in the final clocks of a frame is still chained
    begin
      int l0;
      l0 = latches;
      tick_once();
      @(negedge clk);
      while (!(mon_slot == ROWS && !latch_n)) @(negedge clk);
      tick_once();
      wait_idle();
      check(latches - l0 == 2 * (ROWS + 1), "R11 late tick chained", latches - l0, 2 * (ROWS + 1));
    end

    repeat (10) @(negedge clk);
    check(!busy && latch_n && !sclk, "R3 idle after frames", {busy, latch_n, sclk}, 3'b010);
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule